// File: doc/BRIEF.md
# Fixed Memory Window Interleave Router

This block sits behind one host physical address window and spreads the traffic that lands in it across a set of downstream host-bridge ports. Each request carries an offset into the window. The block adds the window base to form the host address, picks a port by interleaving the host address across the configured number of targets, and forwards the request with the full host address to that port. It then returns the port's response upstream.

The window is described by static configuration inputs: base, size, target count, an encoded interleave granularity and a mask of the ports that are actually populated. The target count may be any value from one to the number of ports, because the port is chosen by a modulo and not by taking address bits. A configuration checker reports whether the setup is legal.

When a request cannot be routed, the block finishes it locally and nothing goes downstream. This happens when the configuration is illegal, when the offset falls outside the window, or when the chosen port is not populated. Such a read returns zero data with an error. Such a write is dropped and reported as a success. Requests are handled one at a time, with valid/ready handshakes on the upstream request and response and on the downstream request.

Top module: `fmw_router`

## Requirements
- R1: A routed request appears on the downstream port with `dn_req_addr` equal to `cfg_base + up_req_offset`, truncated to ADDR_W bits.
- R2: The chosen port index is `((cfg_base + up_req_offset) >> (8 + cfg_gran_enc)) % cfg_targets`. Granularity code g means 256 << g bytes, so code 0 is 256-byte interleave.
- R3: `cfg_ok` is 1 only when all three of these hold: `cfg_targets` is between 1 and NUM_PORTS, `cfg_size` is nonzero with its low 28 bits zero (a whole multiple of 256 MiB), and `cfg_gran_enc` is at most 6.
- R4: While `cfg_ok` is 0, every request is completed locally and no downstream request is raised.
- R5: A request whose offset is not below `cfg_size`, or whose chosen port has its bit clear in `cfg_port_present`, is completed locally.
- R6: A locally completed read responds with `up_rsp_err` = 1 and `up_rsp_rdata` = 0.
- R7: A locally completed write responds with `up_rsp_err` = 0.
- R8: The access length code L (0 to 7) means L+1 bytes, and any byte alignment of the offset is accepted. The length code, the write flag and the write data go downstream unchanged. Data is little-endian: byte k of the access sits in data bits [8k+7:8k].
- R9: A routed response passes the downstream error flag through. For reads, data byte lanes above the access length are returned as zero.
- R10: Only one transaction is in flight. `up_req_ready` stays 0 from acceptance until the upstream response handshake completes. A raised downstream request and a raised upstream response hold steady until they are taken.
- R11: One clock edge after acceptance, a routed request is raised on exactly its chosen port, or a locally completed response is presented. The response to a routed request is presented one edge after the downstream response is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | ADDR_W | Window base host address |
| cfg_size | input | ADDR_W | Window size in bytes |
| cfg_targets | input | TGT_W | Number of interleave targets |
| cfg_gran_enc | input | 3 | Granularity code, 256 << code bytes |
| cfg_port_present | input | NUM_PORTS | Per-port populated flags |
| cfg_ok | output | 1 | Configuration legal |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Upstream request accepted |
| up_req_write | input | 1 | 1 = write, 0 = read |
| up_req_offset | input | ADDR_W | Offset into the window |
| up_req_len | input | LEN_W | Access length minus one, in bytes |
| up_req_wdata | input | DATA_W | Write data, little-endian |
| up_rsp_valid | output | 1 | Upstream response valid |
| up_rsp_ready | input | 1 | Upstream response taken |
| up_rsp_err | output | 1 | Response error |
| up_rsp_rdata | output | DATA_W | Read data |
| dn_req_valid | output | NUM_PORTS | Per-port downstream request valid |
| dn_req_ready | input | NUM_PORTS | Per-port downstream request ready |
| dn_req_write | output | 1 | Downstream write flag |
| dn_req_addr | output | ADDR_W | Full host address |
| dn_req_len | output | LEN_W | Length code |
| dn_req_wdata | output | DATA_W | Write data |
| dn_rsp_valid | input | NUM_PORTS | Per-port response valid |
| dn_rsp_err | input | NUM_PORTS | Per-port response error |
| dn_rsp_rdata | input | NUM_PORTS*DATA_W | Per-port read data, port p at [p*DATA_W +: DATA_W] |

## Verification
A request is accepted on the rising edge where `up_req_valid` meets `up_req_ready`. The bench samples on the falling edge that follows. At that point a routed request must already show on exactly one port's `dn_req_valid`, and a locally completed request must already show `up_rsp_valid`. The bench's downstream model raises its response on a falling edge, and the upstream response is checked on the next falling edge. All stimulus changes on falling edges, so every sample is one settled half-cycle away from the edge that produced it. Stalls on the downstream ready and on the upstream response ready stretch these windows, and the bench checks that the held signals do not move during them.

// File: rtl/fmw_pkg.sv
package fmw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } fmw_state_e;

  // smallest interleave chunk is 2^8 bytes
  localparam int unsigned GRAN_BASE_LOG2 = 8;
  // largest legal granularity code
  localparam int unsigned GRAN_ENC_MAX   = 6;
  // window size alignment, 2^28 bytes
  localparam int unsigned SIZE_ALIGN_LOG2 = 28;

endpackage

// File: rtl/fmw_cfg_check.sv
module fmw_cfg_check
  import fmw_pkg::*;
#(
  parameter int unsigned ADDR_W    = 48,
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned TGT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_size,
  input  logic [TGT_W-1:0]  cfg_targets,
  input  logic [2:0]        cfg_gran_enc,
  output logic              cfg_ok
);

  logic count_ok;
  logic size_ok;
  logic gran_ok;

  // target count must select at least one and no more than the ports built
  always_comb begin
    count_ok = (cfg_targets != '0) && (32'(cfg_targets) <= NUM_PORTS);
  end

  // window size must be a nonzero whole number of aligned blocks
  always_comb begin
    size_ok = (cfg_size != '0) && (cfg_size[SIZE_ALIGN_LOG2-1:0] == '0);
  end

  always_comb begin
    gran_ok = (32'(cfg_gran_enc) <= GRAN_ENC_MAX);
  end

  assign cfg_ok = count_ok && size_ok && gran_ok;

  AST_BAD_GRAN_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_gran_enc == 3'd7) |-> !cfg_ok);  // R3
  AST_ZERO_TARGETS_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_targets == '0) |-> !cfg_ok);  // R3

endmodule

// File: rtl/fmw_target_sel.sv
module fmw_target_sel
  import fmw_pkg::*;
#(
  parameter int unsigned ADDR_W    = 48,
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned TGT_W     = 4,
  parameter int unsigned PORT_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    cfg_base,
  input  logic [ADDR_W-1:0]    cfg_size,
  input  logic [TGT_W-1:0]     cfg_targets,
  input  logic [2:0]           cfg_gran_enc,
  input  logic [NUM_PORTS-1:0] cfg_port_present,
  input  logic                 cfg_ok,
  input  logic [ADDR_W-1:0]    offset,
  output logic [ADDR_W-1:0]    host_addr,
  output logic [PORT_W-1:0]    port_idx,
  output logic                 routable
);

  logic [ADDR_W-1:0] chunk;
  logic [ADDR_W-1:0] divisor;
  logic [ADDR_W-1:0] remainder;
  logic [3:0]        shamt;
  logic              in_window;
  logic              port_here;

  // full host address: base added before any routing decision
  assign host_addr = cfg_base + offset;

  // granule number of the host address
  always_comb begin
    shamt = 4'(GRAN_BASE_LOG2) + {1'b0, cfg_gran_enc};
    chunk = host_addr >> shamt;
  end

  // modulo over the configured target count; guard the zero count
  always_comb begin
    divisor   = (cfg_targets == '0) ? ADDR_W'(1) : ADDR_W'(cfg_targets);
    remainder = chunk % divisor;
    port_idx  = PORT_W'(remainder);
  end

  always_comb begin
    in_window = (offset < cfg_size);
    port_here = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (port_idx == PORT_W'(p)) port_here = cfg_port_present[p];
    end
    routable = cfg_ok && in_window && port_here;
  end

  AST_INDEX_BELOW_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok |-> (32'(port_idx) < 32'(cfg_targets)));  // R2
  AST_BAD_CFG_NOT_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ok |-> !routable);  // R4
  AST_OUTSIDE_NOT_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
    (offset >= cfg_size) |-> !routable);  // R5

endmodule

// File: rtl/fmw_txn_ctrl.sv
module fmw_txn_ctrl
  import fmw_pkg::*;
#(
  parameter int unsigned ADDR_W    = 48,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned PORT_W    = 3,
  parameter int unsigned LEN_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  // upstream request
  input  logic                        up_req_valid,
  output logic                        up_req_ready,
  input  logic                        up_req_write,
  input  logic [LEN_W-1:0]            up_req_len,
  input  logic [DATA_W-1:0]           up_req_wdata,
  // routing decision for the request on the bus
  input  logic [ADDR_W-1:0]           route_addr,
  input  logic [PORT_W-1:0]           route_port,
  input  logic                        route_ok,
  // upstream response
  output logic                        up_rsp_valid,
  input  logic                        up_rsp_ready,
  output logic                        up_rsp_err,
  output logic [DATA_W-1:0]           up_rsp_rdata,
  // downstream
  output logic [NUM_PORTS-1:0]        dn_req_valid,
  input  logic [NUM_PORTS-1:0]        dn_req_ready,
  output logic                        dn_req_write,
  output logic [ADDR_W-1:0]           dn_req_addr,
  output logic [LEN_W-1:0]            dn_req_len,
  output logic [DATA_W-1:0]           dn_req_wdata,
  input  logic [NUM_PORTS-1:0]        dn_rsp_valid,
  input  logic [NUM_PORTS-1:0]        dn_rsp_err,
  input  logic [NUM_PORTS*DATA_W-1:0] dn_rsp_rdata
);

  localparam int unsigned NBYTES = DATA_W / 8;

  fmw_state_e state_q, state_d;

  logic [PORT_W-1:0] sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic              write_q;
  logic [LEN_W-1:0]  len_q;
  logic [DATA_W-1:0] wdata_q;
  logic              cmd_en;

  logic              rsp_err_q, rsp_err_d;
  logic [DATA_W-1:0] rsp_rdata_q, rsp_rdata_d;
  logic              rsp_en;

  logic              accept;
  logic              sel_ready;
  logic              sel_rsp_valid;
  logic              sel_rsp_err;
  logic [DATA_W-1:0] sel_rsp_rdata;
  logic [DATA_W-1:0] lane_mask;

  assign up_req_ready = (state_q == ST_IDLE);
  assign accept       = up_req_valid && up_req_ready;

  // pick the signals of the port holding the transaction
  always_comb begin
    sel_ready     = 1'b0;
    sel_rsp_valid = 1'b0;
    sel_rsp_err   = 1'b0;
    sel_rsp_rdata = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (sel_q == PORT_W'(p)) begin
        sel_ready     = dn_req_ready[p];
        sel_rsp_valid = dn_rsp_valid[p];
        sel_rsp_err   = dn_rsp_err[p];
        sel_rsp_rdata = dn_rsp_rdata[p*DATA_W +: DATA_W];
      end
    end
  end

  // byte lanes kept for a read of len_q+1 bytes
  always_comb begin
    for (int b = 0; b < NBYTES; b++) begin
      lane_mask[b*8 +: 8] = (LEN_W'(b) <= len_q) ? 8'hFF : 8'h00;
    end
  end

  // next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept) state_d = route_ok ? ST_ISSUE : ST_RESP;
      ST_ISSUE: if (sel_ready) state_d = ST_WAIT;
      ST_WAIT:  if (sel_rsp_valid) state_d = ST_RESP;
      ST_RESP:  if (up_rsp_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign cmd_en = accept;

  // response capture: local completion or downstream answer
  always_comb begin
    rsp_en      = 1'b0;
    rsp_err_d   = rsp_err_q;
    rsp_rdata_d = rsp_rdata_q;
    if (accept && !route_ok) begin
      rsp_en      = 1'b1;
      rsp_err_d   = !up_req_write;
      rsp_rdata_d = '0;
    end else if ((state_q == ST_WAIT) && sel_rsp_valid) begin
      rsp_en      = 1'b1;
      rsp_err_d   = sel_rsp_err;
      rsp_rdata_d = write_q ? '0 : (sel_rsp_rdata & lane_mask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      addr_q  <= '0;
      write_q <= 1'b0;
      len_q   <= '0;
      wdata_q <= '0;
    end else if (cmd_en) begin
      sel_q   <= route_port;
      addr_q  <= route_addr;
      write_q <= up_req_write;
      len_q   <= up_req_len;
      wdata_q <= up_req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else if (rsp_en) begin
      rsp_err_q   <= rsp_err_d;
      rsp_rdata_q <= rsp_rdata_d;
    end
  end

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dn_valid
      assign dn_req_valid[p] = (state_q == ST_ISSUE) && (sel_q == PORT_W'(p));
    end
  endgenerate

  assign dn_req_write = write_q;
  assign dn_req_addr  = addr_q;
  assign dn_req_len   = len_q;
  assign dn_req_wdata = wdata_q;

  assign up_rsp_valid = (state_q == ST_RESP);
  assign up_rsp_err   = rsp_err_q;
  assign up_rsp_rdata = rsp_rdata_q;

  AST_DN_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dn_req_valid & ~dn_req_ready)) |=> ($stable(dn_req_valid) && $stable(dn_req_addr)));  // R10
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (|dn_req_valid) |-> !up_req_ready);  // R10
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid && !up_rsp_ready) |=> (up_rsp_valid && $stable(up_rsp_err) && $stable(up_rsp_rdata)));  // R10
  AST_LOCAL_READ_POISON: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !route_ok && !up_req_write) |=> (up_rsp_valid && up_rsp_err && (up_rsp_rdata == '0)));  // R6
  AST_LOCAL_WRITE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !route_ok && up_req_write) |=> (up_rsp_valid && !up_rsp_err && (dn_req_valid == '0)));  // R7
  AST_ROUTED_ISSUE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && route_ok) |=> ($countones(dn_req_valid) == 1));  // R11

endmodule

// File: rtl/fmw_router.sv
module fmw_router
  import fmw_pkg::*;
#(
  parameter int unsigned ADDR_W    = 48,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned NUM_PORTS = 8,
  localparam int unsigned TGT_W    = $clog2(NUM_PORTS + 1),
  localparam int unsigned PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int unsigned LEN_W    = $clog2(DATA_W / 8)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           cfg_base,
  input  logic [ADDR_W-1:0]           cfg_size,
  input  logic [TGT_W-1:0]            cfg_targets,
  input  logic [2:0]                  cfg_gran_enc,
  input  logic [NUM_PORTS-1:0]        cfg_port_present,
  output logic                        cfg_ok,
  input  logic                        up_req_valid,
  output logic                        up_req_ready,
  input  logic                        up_req_write,
  input  logic [ADDR_W-1:0]           up_req_offset,
  input  logic [LEN_W-1:0]            up_req_len,
  input  logic [DATA_W-1:0]           up_req_wdata,
  output logic                        up_rsp_valid,
  input  logic                        up_rsp_ready,
  output logic                        up_rsp_err,
  output logic [DATA_W-1:0]           up_rsp_rdata,
  output logic [NUM_PORTS-1:0]        dn_req_valid,
  input  logic [NUM_PORTS-1:0]        dn_req_ready,
  output logic                        dn_req_write,
  output logic [ADDR_W-1:0]           dn_req_addr,
  output logic [LEN_W-1:0]            dn_req_len,
  output logic [DATA_W-1:0]           dn_req_wdata,
  input  logic [NUM_PORTS-1:0]        dn_rsp_valid,
  input  logic [NUM_PORTS-1:0]        dn_rsp_err,
  input  logic [NUM_PORTS*DATA_W-1:0] dn_rsp_rdata
);

  logic [ADDR_W-1:0] route_addr;
  logic [PORT_W-1:0] route_port;
  logic              route_ok;

  fmw_cfg_check #(
    .ADDR_W    (ADDR_W),
    .NUM_PORTS (NUM_PORTS),
    .TGT_W     (TGT_W)
  ) i_cfg_check (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_size     (cfg_size),
    .cfg_targets  (cfg_targets),
    .cfg_gran_enc (cfg_gran_enc),
    .cfg_ok       (cfg_ok)
  );

  fmw_target_sel #(
    .ADDR_W    (ADDR_W),
    .NUM_PORTS (NUM_PORTS),
    .TGT_W     (TGT_W),
    .PORT_W    (PORT_W)
  ) i_target_sel (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_base         (cfg_base),
    .cfg_size         (cfg_size),
    .cfg_targets      (cfg_targets),
    .cfg_gran_enc     (cfg_gran_enc),
    .cfg_port_present (cfg_port_present),
    .cfg_ok           (cfg_ok),
    .offset           (up_req_offset),
    .host_addr        (route_addr),
    .port_idx         (route_port),
    .routable         (route_ok)
  );

  fmw_txn_ctrl #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W),
    .LEN_W     (LEN_W)
  ) i_txn_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .up_req_valid (up_req_valid),
    .up_req_ready (up_req_ready),
    .up_req_write (up_req_write),
    .up_req_len   (up_req_len),
    .up_req_wdata (up_req_wdata),
    .route_addr   (route_addr),
    .route_port   (route_port),
    .route_ok     (route_ok),
    .up_rsp_valid (up_rsp_valid),
    .up_rsp_ready (up_rsp_ready),
    .up_rsp_err   (up_rsp_err),
    .up_rsp_rdata (up_rsp_rdata),
    .dn_req_valid (dn_req_valid),
    .dn_req_ready (dn_req_ready),
    .dn_req_write (dn_req_write),
    .dn_req_addr  (dn_req_addr),
    .dn_req_len   (dn_req_len),
    .dn_req_wdata (dn_req_wdata),
    .dn_rsp_valid (dn_rsp_valid),
    .dn_rsp_err   (dn_rsp_err),
    .dn_rsp_rdata (dn_rsp_rdata)
  );

  AST_ROUTED_ADDR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req_valid && up_req_ready && route_ok) |=> (dn_req_addr == $past(cfg_base + up_req_offset)));  // R1

endmodule

// File: tb/test_fmw_router.sv
module test_fmw_router;

  localparam int NP = 8;
  localparam int AW = 48;
  localparam int DW = 64;

  logic            clk;
  logic            rst_n;
  logic [AW-1:0]   cfg_base, cfg_size;
  logic [3:0]      cfg_targets;
  logic [2:0]      cfg_gran_enc;
  logic [NP-1:0]   cfg_port_present;
  logic            cfg_ok;
  logic            up_req_valid, up_req_ready, up_req_write;
  logic [AW-1:0]   up_req_offset;
  logic [2:0]      up_req_len;
  logic [DW-1:0]   up_req_wdata;
  logic            up_rsp_valid, up_rsp_ready, up_rsp_err;
  logic [DW-1:0]   up_rsp_rdata;
  logic [NP-1:0]   dn_req_valid, dn_req_ready;
  logic            dn_req_write;
  logic [AW-1:0]   dn_req_addr;
  logic [2:0]      dn_req_len;
  logic [DW-1:0]   dn_req_wdata;
  logic [NP-1:0]   dn_rsp_valid, dn_rsp_err;
  logic [NP*DW-1:0] dn_rsp_rdata;

  fmw_router i_fmw_router (
    .clk(clk), .rst_n(rst_n),
    .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_targets(cfg_targets),
    .cfg_gran_enc(cfg_gran_enc), .cfg_port_present(cfg_port_present), .cfg_ok(cfg_ok),
    .up_req_valid(up_req_valid), .up_req_ready(up_req_ready), .up_req_write(up_req_write),
    .up_req_offset(up_req_offset), .up_req_len(up_req_len), .up_req_wdata(up_req_wdata),
    .up_rsp_valid(up_rsp_valid), .up_rsp_ready(up_rsp_ready), .up_rsp_err(up_rsp_err),
    .up_rsp_rdata(up_rsp_rdata),
    .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready), .dn_req_write(dn_req_write),
    .dn_req_addr(dn_req_addr), .dn_req_len(dn_req_len), .dn_req_wdata(dn_req_wdata),
    .dn_rsp_valid(dn_rsp_valid), .dn_rsp_err(dn_rsp_err), .dn_rsp_rdata(dn_rsp_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int n_checks = 0;
  int n_fails  = 0;

  // downstream model knobs and record
  int          rdy_dly   = 0;
  int          rsp_dly   = 0;
  logic        rsp_err_k = 1'b0;
  bit          seen_req;
  int          seen_port;
  logic [AW-1:0] seen_addr;
  logic        seen_write;
  logic [2:0]  seen_len;
  logic [DW-1:0] seen_wdata;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pattern(input logic [AW-1:0] a, input int p);
    return {16'hBEEF, a} ^ {56'h0, 8'(p)};
  endfunction

  function automatic logic [DW-1:0] byte_mask(input logic [2:0] len);
    logic [DW-1:0] m = '0;
    for (int b = 0; b <= int'(len); b++) m[b*8 +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic int expect_port(input logic [AW-1:0] off);
    longint unsigned h = 64'(AW'(cfg_base + off));
    return int'((h >> (8 + int'(cfg_gran_enc))) % longint'(cfg_targets));
  endfunction

  // downstream responder
  initial begin
    dn_req_ready = '0;
    dn_rsp_valid = '0;
    dn_rsp_err   = '0;
    dn_rsp_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n && (|dn_req_valid)) begin
        int p = 0;
        for (int i = 0; i < NP; i++) if (dn_req_valid[i]) p = i;
        seen_req   = 1'b1;
        seen_port  = p;
        seen_addr  = dn_req_addr;
        seen_write = dn_req_write;
        seen_len   = dn_req_len;
        seen_wdata = dn_req_wdata;
        repeat (rdy_dly) begin
          @(negedge clk);
          check(dn_req_valid == NP'(1 << p) && dn_req_addr == seen_addr,
                "R10 dn request held while not ready", 64'(dn_req_valid), 64'(1 << p));
        end
        dn_req_ready[p] = 1'b1;
        @(negedge clk);
        dn_req_ready = '0;
        repeat (rsp_dly) @(negedge clk);
        dn_rsp_valid[p] = 1'b1;
        dn_rsp_err[p]   = rsp_err_k;
        dn_rsp_rdata[p*DW +: DW] = pattern(seen_addr, p);
        @(negedge clk);
        dn_rsp_valid = '0;
        dn_rsp_err   = '0;
      end
    end
  end

  // one complete transaction with its own checks
  task automatic do_txn(input bit wr, input logic [AW-1:0] off, input logic [2:0] len,
                        input logic [DW-1:0] wd, input bit exp_route, input string tag);
    int  ep = exp_route ? expect_port(off) : 0;
    int  waitc = 0;
    seen_req = 1'b0;
    @(negedge clk);
    up_req_valid  = 1'b1;
    up_req_write  = wr;
    up_req_offset = off;
    up_req_len    = len;
    up_req_wdata  = wd;
    @(negedge clk);
    up_req_valid = 1'b0;
    // R11: one edge after acceptance
    if (exp_route)
      check(dn_req_valid == NP'(1 << ep), {tag, " R11/R2 port raised next cycle"},
            64'(dn_req_valid), 64'(1 << ep));
    else
      check(up_rsp_valid && dn_req_valid == '0, {tag, " R11 local response next cycle"},
            64'(up_rsp_valid), 64'(1));
    while (!up_rsp_valid && waitc < 50) begin
      @(negedge clk);
      waitc++;
    end
    if (exp_route) begin
      check(seen_req && seen_port == ep, {tag, " R2 port"}, 64'(seen_port), 64'(ep));
      check(seen_addr == AW'(cfg_base + off), {tag, " R1 host address"}, 64'(seen_addr), 64'(AW'(cfg_base + off)));
      check(seen_len == len && seen_write == wr, {tag, " R8 len/write forwarded"}, 64'(seen_len), 64'(len));
      if (wr) check(seen_wdata == wd, {tag, " R8 wdata"}, seen_wdata, wd);
      check(up_rsp_err == rsp_err_k, {tag, " R9 err passthrough"}, 64'(up_rsp_err), 64'(rsp_err_k));
      if (!wr) check(up_rsp_rdata == (pattern(seen_addr, ep) & byte_mask(len)),
                     {tag, " R9 rdata masked"}, up_rsp_rdata, pattern(seen_addr, ep) & byte_mask(len));
    end else begin
      check(!seen_req, {tag, " R4/R5 nothing sent downstream"}, 64'(seen_req), 64'(0));
      if (wr) check(!up_rsp_err, {tag, " R7 local write ok"}, 64'(up_rsp_err), 64'(0));
      else    check(up_rsp_err && up_rsp_rdata == '0, {tag, " R6 local read poison"}, up_rsp_rdata, 64'(0));
    end
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic [AW-1:0] b, input logic [AW-1:0] s, input int n,
                         input int g, input logic [NP-1:0] pres);
    cfg_base = b; cfg_size = s; cfg_targets = 4'(n); cfg_gran_enc = 3'(g); cfg_port_present = pres;
  endtask

  task automatic t_reset();
    check(up_req_ready && !up_rsp_valid && dn_req_valid == '0, "R10 reset idle state",
          64'(up_req_ready), 64'(1));
  endtask

  task automatic t_cfg();
    set_cfg(48'h1_0000_0000, 48'h1000_0000, 3, 0, '1); #1;
    check(cfg_ok, "R3 legal config", 64'(cfg_ok), 64'(1));
    cfg_targets = 4'd0; #1;
    check(!cfg_ok, "R3 zero targets", 64'(cfg_ok), 64'(0));
    cfg_targets = 4'd9; #1;
    check(!cfg_ok, "R3 too many targets", 64'(cfg_ok), 64'(0));
    cfg_targets = 4'd8; cfg_size = 48'h1800_0000; #1;
    check(!cfg_ok, "R3 unaligned size", 64'(cfg_ok), 64'(0));
    cfg_size = 48'h0; #1;
    check(!cfg_ok, "R3 zero size", 64'(cfg_ok), 64'(0));
    cfg_size = 48'h3000_0000; cfg_gran_enc = 3'd7; #1;
    check(!cfg_ok, "R3 granularity code 7", 64'(cfg_ok), 64'(0));
    cfg_gran_enc = 3'd6; #1;
    check(cfg_ok, "R3 granularity code 6", 64'(cfg_ok), 64'(1));
  endtask

  task automatic t_default_gran();
    set_cfg(48'h1_0000_0000, 48'h1000_0000, 3, 0, '1);
    rdy_dly = 0; rsp_dly = 0; rsp_err_k = 1'b0;
    for (int i = 0; i < 6; i++)
      do_txn(1'b0, AW'(i * 256 + 16), 3'd7, '0, 1'b1, "R2 256B interleave");
  endtask

  task automatic t_coarse_gran();
    set_cfg(48'h2_3000_0000, 48'h2000_0000, 5, 2, '1);
    rdy_dly = 2; rsp_dly = 1;
    for (int i = 0; i < 7; i++)
      do_txn(1'b1, AW'(i * 1024 + 3), 3'd3, 64'h1122_3344_5566_7788 + 64'(i), 1'b1, "R2 1KiB interleave");
    do_txn(1'b0, 48'h1FFF_FFF8, 3'd7, '0, 1'b1, "R5 last bytes of window");
  endtask

  task automatic t_lengths();
    set_cfg(48'h4000_0000, 48'h1000_0000, 7, 1, '1);
    rdy_dly = 0; rsp_dly = 2;
    for (int l = 0; l < 8; l++)
      do_txn(1'b0, AW'(l * 37 + 1), 3'(l), '0, 1'b1, "R8/R9 unaligned length");
    rsp_err_k = 1'b1;
    do_txn(1'b0, 48'h205, 3'd1, '0, 1'b1, "R9 downstream error");
    rsp_err_k = 1'b0;
  endtask

  task automatic t_local();
    set_cfg(48'h1_0000_0000, 48'h1000_0000, 4, 0, '1);
    do_txn(1'b0, 48'h1000_0000, 3'd7, '0, 1'b0, "R5 read at window end");
    do_txn(1'b1, 48'h1000_0100, 3'd7, 64'hFF, 1'b0, "R5 write past window");
    cfg_port_present = 8'b1111_1011;  // port 2 missing
    do_txn(1'b0, 48'h200, 3'd0, '0, 1'b0, "R5 absent port read");
    do_txn(1'b1, 48'h600, 3'd0, 64'h5A, 1'b0, "R5 absent port write");
    do_txn(1'b0, 48'h300, 3'd0, '0, 1'b1, "R5 present port still routed");
    cfg_targets = 4'd0;
    do_txn(1'b0, 48'h0, 3'd7, '0, 1'b0, "R4 illegal config read");
    do_txn(1'b1, 48'h0, 3'd7, 64'h1, 1'b0, "R4 illegal config write");
    cfg_targets = 4'd4; cfg_gran_enc = 3'd7;
    do_txn(1'b0, 48'h0, 3'd7, '0, 1'b0, "R4 bad granularity read");
  endtask

  task automatic t_hold();
    set_cfg(48'h1_0000_0000, 48'h1000_0000, 2, 0, '1);
    @(negedge clk);
    up_rsp_ready  = 1'b0;
    up_req_valid  = 1'b1;
    up_req_write  = 1'b0;
    up_req_offset = 48'h1000_0000;
    @(negedge clk);
    up_req_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check(up_rsp_valid && up_rsp_err && !up_req_ready, "R10 response held, no accept",
            64'(up_req_ready), 64'(0));
      @(negedge clk);
    end
    up_rsp_ready = 1'b1;
    @(negedge clk);
    check(!up_rsp_valid && up_req_ready, "R10 released after handshake", 64'(up_rsp_valid), 64'(0));
    rdy_dly = 4; rsp_dly = 0;
    do_txn(1'b0, 48'h140, 3'd7, '0, 1'b1, "R10 slow downstream ready");
  endtask

  initial begin
    #(200000 * 8);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    up_req_valid = 1'b0; up_req_write = 1'b0; up_req_offset = '0;
    up_req_len = '0; up_req_wdata = '0; up_rsp_ready = 1'b1;
    set_cfg(48'h1_0000_0000, 48'h1000_0000, 3, 0, '1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_default_gran();
    t_coarse_gran();
    t_lengths();
    t_local();
    t_hold();
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule